// File: doc/BRIEF.md
# Indexed Audio Codec Control Register Interface

This block is the host-facing control window of an audio codec. The host sees four byte-wide ports: an index port, a data window, a status port and a programmed-I/O data port. It selects one of the internal control registers through the index port and then reads or writes that register through the data window. The bank holds 32 registers. Only the first 16 can be reached until an extended-mode bit is set, and then all 32 can be reached.

The block loads reset defaults and applies the write rules of each register. Some bits are forced to zero. The error register is read-only. The mode register accepts only its extended-mode bit. The sample-format register takes writes only while a mode-change enable is active, or while a playback-only mode-change enable is active; in the second case the sample-rate nibble is kept. A one-cycle `pb_irq_set` pulse from the playback engine raises the interrupt. The host clears it through the status port or through the alternate status register. The block also models autocalibration: when the mode-change enable rises, a busy indication is armed and stays visible for a fixed number of reads of the error register. The decoded format fields and the playback enable are brought out as wires.

Top module: `codec_regif`

## Requirements
- R1: After reset the index port reads 0x40 (mode-change enable, bit 6, set) and `irq_o` is 0. The indirect registers hold 0x88 at indices 2, 3, 4, 5, 18 and 19, 0x80 at 6 and 7, 0x08 at 9, 0x8A at 12, and 0xA0 at 25 and 26. Every other register holds 0x00.
- R2: Port 0 stores the written byte with bit 7 cleared, and reads return that value. Port 3 always reads 0x00, and writes to it change nothing.
- R3: The indirect register is selected by index bits 3:0. When bit 6 of register 12 is 1, it is selected by index bits 4:0 instead.
- R4: A data write to register 12 changes only its bit 6.
- R5: While index bit 6 is 1, a data write to register 8 stores the full byte.
- R6: While index bit 6 is 0 and bit 0 of register 24 is 1, a write to register 8 stores the new bits 7:4 and keeps the old bits 3:0. While both are 0, the write is ignored.
- R7: A write to register 9 stores the byte with bit 5 forced to 0.
- R8: Writes to register 11 are ignored.
- R9: Any write to port 2 clears the status INT bit (bit 0 of port 2), clears bits 6:4 of register 24 and drives `irq_o` low.
- R10: A write to register 24 that finds bit 4 set and writes bit 4 as 0 clears INT and `irq_o`.
- R11: A `pb_irq_set` pulse sets INT, `irq_o` and bit 4 of register 24. If it arrives in the same cycle as a clear, the set wins.
- R12: A port-0 write that moves index bit 6 from 0 to 1, while bits 4:3 of register 9 are nonzero, loads a busy count of ACI_LOAD. A data read of register 11 with a nonzero count returns bit 5 set and decrements the count. With a zero count, bit 5 reads 0.
- R13: The outputs are taken from register 8, register 9 and register 12. `fmt_xtal` is reg8[0], `fmt_rate` is reg8[3:1], `fmt_stereo` is reg8[4] and `play_en` is reg9[0]. `fmt_code` is reg8[7:5] in extended mode; otherwise it is {0, reg8[6:5]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 PIO |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects take effect at the clock) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| pb_irq_set | input | 1 | Playback interrupt event pulse |
| irq_o | output | 1 | Interrupt request |
| mode_ext | output | 1 | Extended (32-register) mode |
| mce_o | output | 1 | Mode-change enable |
| fmt_xtal | output | 1 | Clock source select |
| fmt_rate | output | 3 | Rate divider select |
| fmt_stereo | output | 1 | Stereo select |
| fmt_code | output | 3 | Sample encoding code |
| play_en | output | 1 | Playback enable |

## Verification
The bench targets the following corner cases:
- Index width. An index with bit 4 set is used in both modes. A design that always decodes five bits would return the version register where it should alias to register 9.
- Format-register gating. A write under the playback-only enable must keep the rate nibble. A design that takes the full byte or drops the write fails the merged read-back. A write with neither enable set must leave the register unchanged.
- Interrupt clearing. A write to register 24 that keeps bit 4 set must leave the interrupt asserted, while a write that clears bit 4 must drop it.
- Autocalibration. The busy count must expire after exactly ACI_LOAD reads, and it must not arm when register 9 bits 4:3 are zero. An off-by-one count would show busy one read too many or too few.

// File: rtl/codec_regif.sv
module codec_regif #(
  parameter int ACI_LOAD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       pb_irq_set,
  output logic       irq_o,
  output logic       mode_ext,
  output logic       mce_o,
  output logic       fmt_xtal,
  output logic [2:0] fmt_rate,
  output logic       fmt_stereo,
  output logic [2:0] fmt_code,
  output logic       play_en
);
  localparam int NREG = 32;
  localparam int CW   = $clog2(ACI_LOAD + 1);
  localparam logic [4:0] R_FMT = 5'd8, R_CFG = 5'd9, R_ERR = 5'd11,
                         R_MODE = 5'd12, R_AST = 5'd24;

  logic [7:0]    idx_q;
  logic [7:0]    bank [NREG];
  logic          int_q;
  logic [CW-1:0] aci_q;

  function automatic logic [7:0] dflt(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: dflt = 8'h88;
      6, 7:               dflt = 8'h80;
      9:                  dflt = 8'h08;
      12:                 dflt = 8'h8A;
      25, 26:             dflt = 8'hA0;
      default:            dflt = 8'h00;
    endcase
  endfunction

  assign mode_ext = bank[R_MODE][6];
  assign mce_o    = idx_q[6];

  logic [4:0] iaddr;
  assign iaddr = mode_ext ? idx_q[4:0] : {1'b0, idx_q[3:0]};

  logic wr_idx, wr_dat, wr_sts, rd_err;
  assign wr_idx = bus_wr && bus_addr == 2'd0;
  assign wr_dat = bus_wr && bus_addr == 2'd1;
  assign wr_sts = bus_wr && bus_addr == 2'd2;
  assign rd_err = bus_rd && bus_addr == 2'd1 && iaddr == R_ERR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h40;
      int_q <= 1'b0;
      aci_q <= '0;
      for (int i = 0; i < NREG; i++) bank[i] <= dflt(i);
    end else begin
      if (wr_idx) begin
        idx_q <= bus_wdata & 8'h7F;
        if (!idx_q[6] && bus_wdata[6] && (bank[R_CFG][4:3] != 2'b00))
          aci_q <= CW'(ACI_LOAD);
      end
      if (rd_err && aci_q != '0) aci_q <= aci_q - 1'b1;
      if (wr_dat) begin
        case (iaddr)
          R_FMT: begin
            if (idx_q[6]) bank[R_FMT] <= bus_wdata;
            else if (bank[R_AST][0]) bank[R_FMT] <= {bus_wdata[7:4], bank[R_FMT][3:0]};
          end
          R_CFG:  bank[R_CFG] <= bus_wdata & 8'hDF;
          R_ERR:  ;
          R_MODE: bank[R_MODE][6] <= bus_wdata[6];
          R_AST: begin
            bank[R_AST] <= bus_wdata;
            if (bank[R_AST][4] && !bus_wdata[4]) int_q <= 1'b0;
          end
          default: bank[iaddr] <= bus_wdata;
        endcase
      end
      if (wr_sts) begin
        int_q <= 1'b0;
        bank[R_AST][6:4] <= 3'b000;
      end
      if (pb_irq_set) begin
        int_q <= 1'b1;
        bank[R_AST][4] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = idx_q & 8'h7F;
      2'd1: begin
        if (iaddr == R_ERR)
          bus_rdata = (aci_q != '0) ? (bank[R_ERR] | 8'h20) : (bank[R_ERR] & 8'hDF);
        else
          bus_rdata = bank[iaddr];
      end
      2'd2:    bus_rdata = {7'b0, int_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_o      = int_q;
  assign fmt_xtal   = bank[R_FMT][0];
  assign fmt_rate   = bank[R_FMT][3:1];
  assign fmt_stereo = bank[R_FMT][4];
  assign fmt_code   = mode_ext ? bank[R_FMT][7:5] : {1'b0, bank[R_FMT][6:5]};
  assign play_en    = bank[R_CFG][0];

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pb_irq_set));
  // R9
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !pb_irq_set) |=> !irq_o);
  // R10
  ast_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && iaddr == R_AST && bank[R_AST][4] && !bus_wdata[4] && !pb_irq_set) |=> !irq_o);
  // R6
  fmt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && iaddr == R_FMT && !idx_q[6] && !bank[R_AST][0])
    |=> $stable({fmt_xtal, fmt_rate, fmt_stereo}));
  // R4
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && iaddr == R_MODE) |=> (bank[R_MODE][5:0] == 6'h0A && bank[R_MODE][7]));
endmodule

// File: tb/sim_codec_regif.sv
module sim_codec_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, pb_irq_set = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o, mode_ext, mce_o, fmt_xtal, fmt_stereo, play_en;
  logic [2:0] fmt_rate, fmt_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_regif #(.ACI_LOAD(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pb_irq_set(pb_irq_set), .irq_o(irq_o),
    .mode_ext(mode_ext), .mce_o(mce_o), .fmt_xtal(fmt_xtal), .fmt_rate(fmt_rate),
    .fmt_stereo(fmt_stereo), .fmt_code(fmt_code), .play_en(play_en));

  // entry: tag(16) | is_read | port | data-or-expected
  localparam int NV = 31;
  localparam logic [26:0] VEC [NV] = '{
    {"R1", 1'b1, 2'd0, 8'h40},
    {"R1", 1'b0, 2'd0, 8'h4C}, {"R1", 1'b1, 2'd1, 8'h8A},
    {"R4", 1'b0, 2'd1, 8'hFF}, {"R4", 1'b1, 2'd1, 8'hCA},
    {"R2", 1'b0, 2'd0, 8'hD9}, {"R2", 1'b1, 2'd0, 8'h59}, {"R3", 1'b1, 2'd1, 8'hA0},
    {"R7", 1'b0, 2'd0, 8'h49}, {"R7", 1'b0, 2'd1, 8'hFF}, {"R7", 1'b1, 2'd1, 8'hDF},
    {"R8", 1'b0, 2'd0, 8'h4B}, {"R8", 1'b0, 2'd1, 8'h55}, {"R8", 1'b1, 2'd1, 8'h00},
    {"R5", 1'b0, 2'd0, 8'h48}, {"R5", 1'b0, 2'd1, 8'h5A}, {"R5", 1'b1, 2'd1, 8'h5A},
    {"R6", 1'b0, 2'd0, 8'h08}, {"R6", 1'b0, 2'd1, 8'hFF}, {"R6", 1'b1, 2'd1, 8'h5A},
    {"R6", 1'b0, 2'd0, 8'h18}, {"R6", 1'b0, 2'd1, 8'h01},
    {"R6", 1'b0, 2'd0, 8'h08}, {"R6", 1'b0, 2'd1, 8'h37}, {"R6", 1'b1, 2'd1, 8'h3A},
    {"R2", 1'b0, 2'd3, 8'h77}, {"R2", 1'b1, 2'd3, 8'h00},
    {"R3", 1'b0, 2'd0, 8'h0C}, {"R3", 1'b0, 2'd1, 8'h00},
    {"R3", 1'b0, 2'd0, 8'h19}, {"R3", 1'b1, 2'd1, 8'hDF}
  };

  function automatic logic [7:0] exp_reset(input int i);
    if (i inside {2, 3, 4, 5, 18, 19}) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    pb_irq_set = 1'b1;
    @(negedge clk);
    pb_irq_set = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][10]) begin
        rd(VEC[k][9:8], v);
        check(string'(VEC[k][26:11]), v, VEC[k][7:0]);
      end else begin
        wr(VEC[k][9:8], VEC[k][7:0]);
      end
    end

    // R1: full default sweep in extended mode
    do_reset();
    wr(2'd0, 8'h4C); wr(2'd1, 8'hCA);
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'h40 | 8'(i));
      rd(2'd1, v);
      check($sformatf("R1 reg%0d", i), v, (i == 12) ? 8'hCA : exp_reset(i));
    end

    // R13: decoded outputs
    wr(2'd0, 8'h48); wr(2'd1, 8'hB7);
    @(negedge clk);
    check("R13 xtal", {7'b0, fmt_xtal}, 8'h01);
    check("R13 rate", {5'b0, fmt_rate}, 8'h03);
    check("R13 stereo", {7'b0, fmt_stereo}, 8'h01);
    check("R13 code ext", {5'b0, fmt_code}, 8'h05);
    wr(2'd0, 8'h4C); wr(2'd1, 8'h00);
    @(negedge clk);
    check("R13 code std", {5'b0, fmt_code}, 8'h01);
    check("R3 mode_ext", {7'b0, mode_ext}, 8'h00);
    wr(2'd0, 8'h49); wr(2'd1, 8'h01);
    @(negedge clk);
    check("R13 play_en", {7'b0, play_en}, 8'h01);

    // R11 / R9 / R10 interrupt handling
    do_reset();
    wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
    pulse_irq();
    check("R11 irq", {7'b0, irq_o}, 8'h01);
    rd(2'd2, v); check("R11 status", v, 8'h01);
    wr(2'd0, 8'h58); rd(2'd1, v); check("R11 ast", v, 8'h10);
    wr(2'd1, 8'h60);
    wr(2'd2, 8'h00);
    check("R9 irq", {7'b0, irq_o}, 8'h00);
    rd(2'd2, v); check("R9 status", v, 8'h00);
    rd(2'd1, v); check("R9 ast", v, 8'h00);
    pulse_irq();
    wr(2'd1, 8'h10);
    check("R10 keep", {7'b0, irq_o}, 8'h01);
    wr(2'd1, 8'h00);
    check("R10 ack", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    bus_addr = 2'd2; bus_wr = 1'b1; pb_irq_set = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pb_irq_set = 1'b0;
    check("R11 set wins", {7'b0, irq_o}, 8'h01);

    // R12 autocalibration
    do_reset();
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    for (int n = 0; n < 3; n++) begin
      rd(2'd1, v); check($sformatf("R12 busy%0d", n), v, 8'h20);
    end
    rd(2'd1, v); check("R12 expired", v, 8'h00);
    wr(2'd0, 8'h49); wr(2'd1, 8'h00);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R12 no arm", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule